// File: doc/BRIEF.md
# Command Slot Status Tracker

This block keeps the status of a single command slot. Software launches a command by writing the low command word with its go bit set, along with a three-bit mode field. The slot then shows as active until an execution engine signals completion. The completion carries three things: an outcome (normal, exception or hand-off to the operating system), a four-bit substatus and an eighteen-bit cause vector.

The tracker registers the two-bit status, the substatus and the cause vector. It splits the substatus into a message-queue code and an abort-in-progress flag. It decides whether an exception may be retried by checking the cause bits against a fixed set of transient causes. If the launching mode asked for it, it raises a level interrupt at completion. The status and substatus also appear packed at the bit positions that software decodes from the upper half of the first command word.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset, status, substatus, cause vector, retryable flag, interrupt and busy-violation flag are all zero.
- R2: A write of the command word with bit 0 set, while status is not active (code 2), makes status 2 at the next edge and clears substatus and cause. Bits 3:1 are the mode, and mode bit value 4 (word bit 3) arms the completion interrupt.
- R3: A write with bit 0 clear changes nothing. A completion strobe while status is not active changes nothing.
- R4: A write with bit 0 set while status is active is ignored: status and interrupt arming are unchanged. It sets a busy-violation flag that stays high until reset.
- R5: A completion strobe while active sets status at that same edge from the outcome code: 1 gives exception (1), 3 gives call-OS (3), and 0 or 2 give idle (0).
- R6: A completion captures the 4-bit substatus. The message-queue code output is substatus bits 2:0 (0 none, 1 overflow, 2 limit, 3 page overflow, 4 atomic refused, 5 put refused). The abort-active output is substatus bit 3.
- R7: The cause vector is captured on an exception outcome and reads zero for any other outcome.
- R8: Retryable is high only while status is exception, the cause is non-zero and every set cause bit is one of bits 8, 9, 10 or 16.
- R9: An armed command raises irq at its completion. irq holds until an irq_clr strobe, and a set in the same cycle as a clear wins.
- R10: status_word carries status in bits 25:24 and substatus in bits 29:26, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Low command word: bit 0 go, bits 3:1 mode |
| done_vld | input | 1 | Completion strobe from the execution engine |
| done_kind | input | 2 | Completion outcome code |
| done_sub | input | 4 | Completion substatus |
| done_cause | input | 18 | Exception cause vector |
| irq_clr | input | 1 | Interrupt clear strobe |
| status | output | 2 | Slot status: 0 idle, 1 exception, 2 active, 3 call-OS |
| substat | output | 4 | Captured substatus |
| mq_code | output | 3 | Message-queue code (substatus 2:0) |
| abort_active | output | 1 | Implicit abort flag (substatus 3) |
| cause | output | 18 | Captured cause vector |
| retryable | output | 1 | Exception is retryable |
| irq | output | 1 | Completion interrupt level |
| busy_viol | output | 1 | Sticky flag for a start while active |
| status_word | output | 32 | Status and substatus at command-word positions |

## Verification
The hardest cases to reach from the ports are those where events overlap. One is a start write in the same cycle as the completion of an active command. Another is a completion to an armed command in the same cycle as an interrupt clear. A third is a cause vector that sits right on the edge of the retry set: only transient bits, the same bits plus one fatal bit, or all zero. The random stimulus keeps commands in flight by issuing starts and completions at high rates, so starts while active and overlapping strobes occur often. Cause vectors are drawn from weighted classes aimed at the retry boundary. Directed sequences then force each overlap once more on its own.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  localparam int unsigned CAUSE_W = 18;
  localparam int unsigned SUB_W   = 4;
  localparam int unsigned CMD_W   = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXCEPT = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_CALLOS = 2'd3
  } slot_state_e;

  // transient causes: TLB hardware error, two request timeouts, response data error
  localparam logic [CAUSE_W-1:0] RETRY_SET = 18'h10700;

  function automatic slot_state_e outcome_to_state(input logic [1:0] kind);
    case (kind)
      2'd1:    outcome_to_state = ST_EXCEPT;
      2'd3:    outcome_to_state = ST_CALLOS;
      default: outcome_to_state = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/cmd_slot_fsm.sv
module cmd_slot_fsm
  import cmd_slot_pkg::*;
#(
  parameter int unsigned MODE_W  = 3,
  parameter int unsigned IRQ_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic [MODE_W-1:0] mode,
  input  logic              done_vld,
  input  logic [1:0]        done_kind,
  output slot_state_e       state,
  output logic              irq_armed,
  output logic              busy_viol,
  output logic              start_acc,
  output logic              done_acc
);
  slot_state_e state_d;
  logic        armed_d, busy_d;

  always_comb begin
    start_acc = go_req && (state != ST_ACTIVE);
    done_acc  = done_vld && (state == ST_ACTIVE);
    state_d   = state;
    armed_d   = irq_armed;
    busy_d    = busy_viol;
    if (done_acc) begin
      state_d = outcome_to_state(done_kind);
    end else if (start_acc) begin
      state_d = ST_ACTIVE;
      armed_d = mode[IRQ_BIT];
    end
    if (go_req && (state == ST_ACTIVE)) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      irq_armed <= 1'b0;
      busy_viol <= 1'b0;
    end else begin
      state     <= state_d;
      irq_armed <= armed_d;
      busy_viol <= busy_d;
    end
  end

  p_start_goes_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && state != ST_ACTIVE) |=> (state == ST_ACTIVE));
  p_busy_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_viol |=> busy_viol);
  p_active_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && go_req && !done_vld) |=> (state == ST_ACTIVE && $stable(irq_armed) && busy_viol));
  p_done_leaves_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && done_vld) |=> (state != ST_ACTIVE));
  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ACTIVE && !go_req) |=> $stable(state));
endmodule

// File: rtl/cmd_slot_capture.sv
module cmd_slot_capture
  import cmd_slot_pkg::*;
#(
  parameter int unsigned CW = CAUSE_W,
  parameter int unsigned SW = SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          done_acc,
  input  logic [1:0]    done_kind,
  input  logic [SW-1:0] done_sub,
  input  logic [CW-1:0] done_cause,
  output logic [SW-1:0] sub_q,
  output logic [CW-1:0] cause_q
);
  logic [SW-1:0] sub_d;
  logic [CW-1:0] cause_d;
  logic          cap_en;

  assign cap_en = start_acc || done_acc;

  always_comb begin
    sub_d   = '0;
    cause_d = '0;
    if (done_acc) begin
      sub_d = done_sub;
      if (outcome_to_state(done_kind) == ST_EXCEPT) cause_d = done_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      cause_q <= '0;
    end else if (cap_en) begin
      sub_q   <= sub_d;
      cause_q <= cause_d;
    end
  end

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (sub_q == '0 && cause_q == '0));
  p_cause_only_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && done_kind != 2'd1) |=> (cause_q == '0));
  p_hold_no_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !done_acc) |=> ($stable(sub_q) && $stable(cause_q)));
endmodule

// File: rtl/cmd_slot_retry.sv
module cmd_slot_retry
  import cmd_slot_pkg::*;
#(
  parameter int unsigned        CW   = CAUSE_W,
  parameter logic [CW-1:0]      MASK = RETRY_SET
) (
  input  slot_state_e   state,
  input  logic [CW-1:0] cause,
  output logic          retry_ok
);
  logic [CW-1:0] fatal_bit;

  for (genvar b = 0; b < CW; b++) begin : g_bit
    if (MASK[b]) begin : g_transient
      assign fatal_bit[b] = 1'b0;
    end else begin : g_fatal
      assign fatal_bit[b] = cause[b];
    end
  end

  assign retry_ok = (state == ST_EXCEPT) && (|cause) && !(|fatal_bit);

  always_comb begin
    if (retry_ok) p_retry_in_exc_r8: assert ((cause & ~MASK) == '0 && state == ST_EXCEPT);
  end
endmodule

// File: rtl/cmd_slot_irq.sv
module cmd_slot_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_acc,
  input  logic irq_armed,
  input  logic irq_clr,
  output logic irq
);
  logic irq_d, irq_set;

  assign irq_set = done_acc && irq_armed;

  always_comb begin
    irq_d = irq;
    if (irq_clr) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && irq_armed) |=> irq);
  p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !done_acc) |=> !irq);
endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
  import cmd_slot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               done_vld,
  input  logic [1:0]         done_kind,
  input  logic [SUB_W-1:0]   done_sub,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               irq_clr,
  output logic [1:0]         status,
  output logic [SUB_W-1:0]   substat,
  output logic [2:0]         mq_code,
  output logic               abort_active,
  output logic [CAUSE_W-1:0] cause,
  output logic               retryable,
  output logic               irq,
  output logic               busy_viol,
  output logic [CMD_W-1:0]   status_word
);
  localparam int unsigned GO_BIT   = 0;
  localparam int unsigned MODE_LSB = 1;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned ST_LSB   = 24;
  localparam int unsigned SUB_LSB  = ST_LSB + 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  slot_state_e state;
  logic        go_req, start_acc, done_acc, irq_armed;

  assign go_req = cmd_wr && cmd_word[GO_BIT];

  cmd_slot_fsm #(.MODE_W(MODE_W), .IRQ_BIT(2)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go_req    (go_req),
    .mode      (cmd_word[MODE_LSB +: MODE_W]),
    .done_vld  (done_vld),
    .done_kind (done_kind),
    .state     (state),
    .irq_armed (irq_armed),
    .busy_viol (busy_viol),
    .start_acc (start_acc),
    .done_acc  (done_acc)
  );

  cmd_slot_capture #(.CW(CAUSE_W), .SW(SUB_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_acc  (start_acc),
    .done_acc   (done_acc),
    .done_kind  (done_kind),
    .done_sub   (done_sub),
    .done_cause (done_cause),
    .sub_q      (substat),
    .cause_q    (cause)
  );

  cmd_slot_retry #(.CW(CAUSE_W), .MASK(RETRY_SET)) u_retry (
    .state    (state),
    .cause    (cause),
    .retry_ok (retryable)
  );

  cmd_slot_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .done_acc  (done_acc),
    .irq_armed (irq_armed),
    .irq_clr   (irq_clr),
    .irq       (irq)
  );

  assign status       = state;
  assign mq_code      = substat[2:0];
  assign abort_active = substat[3];

  always_comb begin
    status_word = '0;
    status_word[ST_LSB +: 2]      = status;
    status_word[SUB_LSB +: SUB_W] = substat;
  end

  p_exc_cause_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cause != '0) |-> (status == 2'd1));
  p_word_fields_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_word[25:24] == status && status_word[29:26] == substat));
endmodule

// File: tb/cmd_slot_tracker_bench.sv
module cmd_slot_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        done_vld = 1'b0;
  logic [1:0]  done_kind = '0;
  logic [3:0]  done_sub = '0;
  logic [17:0] done_cause = '0;
  logic        irq_clr = 1'b0;
  logic [1:0]  status;
  logic [3:0]  substat;
  logic [2:0]  mq_code;
  logic        abort_active;
  logic [17:0] cause;
  logic        retryable, irq, busy_viol;
  logic [31:0] status_word;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic [1:0]  m_st = 0;
  logic [3:0]  m_sub = 0;
  logic [17:0] m_cause = 0;
  logic        m_arm = 0, m_irq = 0, m_busy = 0;

  always #5 clk = ~clk;

  cmd_slot_tracker u_cmd_slot_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .done_vld(done_vld), .done_kind(done_kind), .done_sub(done_sub),
    .done_cause(done_cause), .irq_clr(irq_clr), .status(status),
    .substat(substat), .mq_code(mq_code), .abort_active(abort_active),
    .cause(cause), .retryable(retryable), .irq(irq), .busy_viol(busy_viol),
    .status_word(status_word)
  );

  function automatic logic exp_retry(input logic [1:0] st, input logic [17:0] c);
    return (st == 2'd1) && (c != 18'd0) && ((c & ~18'h10700) == 18'd0);
  endfunction

  function automatic logic [1:0] exp_state(input logic [1:0] kind);
    if (kind == 2'd1) return 2'd1;
    if (kind == 2'd3) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5 status", 32'(status), 32'(m_st));
    chk("R6 substat", 32'(substat), 32'(m_sub));
    chk("R6 mq_code", 32'(mq_code), 32'(m_sub[2:0]));
    chk("R6 abort_active", 32'(abort_active), 32'(m_sub[3]));
    chk("R7 cause", 32'(cause), 32'(m_cause));
    chk("R8 retryable", 32'(retryable), 32'(exp_retry(m_st, m_cause)));
    chk("R9 irq", 32'(irq), 32'(m_irq));
    chk("R4 busy_viol", 32'(busy_viol), 32'(m_busy));
    chk("R10 status_word", status_word, {2'b00, m_sub, m_st, 24'h0});
  endtask

  // apply current inputs for one edge, update the reference, check at negedge
  task automatic step();
    logic go, st_ok, dn_ok;
    @(posedge clk);
    go    = cmd_wr && cmd_word[0];
    st_ok = go && (m_st != 2'd2);
    dn_ok = done_vld && (m_st == 2'd2);
    if (go && m_st == 2'd2) m_busy = 1'b1;
    if (irq_clr) m_irq = 1'b0;
    if (dn_ok && m_arm) m_irq = 1'b1;
    if (dn_ok) begin
      m_st    = exp_state(done_kind);
      m_sub   = done_sub;
      m_cause = (done_kind == 2'd1) ? done_cause : 18'd0;
    end else if (st_ok) begin
      m_st = 2'd2; m_sub = 0; m_cause = 0; m_arm = cmd_word[3];
    end
    @(negedge clk);
    check_all();
    cmd_wr = 0; done_vld = 0; irq_clr = 0;
  endtask

  task automatic start(input logic [2:0] mode);
    cmd_wr = 1; cmd_word = {28'h0, mode, 1'b1};
    step();
  endtask

  task automatic finish_cmd(input logic [1:0] k, input logic [3:0] s, input logic [17:0] c);
    done_vld = 1; done_kind = k; done_sub = s; done_cause = c;
    step();
  endtask

  function automatic logic [17:0] pick_cause();
    int unsigned sel = $urandom_range(0, 3);
    logic [17:0] m = 18'($urandom) & 18'h10700;
    if (sel == 0) return 18'd0;
    if (sel == 1) return (m == 0) ? 18'h00100 : m;
    if (sel == 2) return m | (18'd1 << $urandom_range(0, 7));
    return 18'($urandom);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all();

    // R3 write without go bit, and a stray completion while idle
    cmd_wr = 1; cmd_word = 32'h0000_000E; step();
    done_vld = 1; done_kind = 2'd1; done_sub = 4'hF; done_cause = 18'h3FFFF; step();

    // R2 start with irq armed, R5/R7/R8 exception with only transient causes
    start(3'b100);
    finish_cmd(2'd1, 4'b1010, 18'h10700);
    // R9 irq held, then cleared
    step();
    irq_clr = 1; step();

    // R4 start while active is ignored, sets busy
    start(3'b000);
    start(3'b100);
    // R9 armed state unchanged: completion must not raise irq
    finish_cmd(2'd3, 4'h5, 18'h00100);

    // R8 exception with a fatal bit mixed in, and with zero cause
    start(3'b000); finish_cmd(2'd1, 4'h1, 18'h10702);
    start(3'b000); finish_cmd(2'd1, 4'h4, 18'h0);
    // R5 outcome 2 maps to idle
    start(3'b000); finish_cmd(2'd2, 4'h2, 18'h00400);

    // R9 set wins over a simultaneous clear
    start(3'b100);
    irq_clr = 1; finish_cmd(2'd0, 4'h3, 18'h0);

    // R4 start and completion in the same cycle
    start(3'b000);
    cmd_wr = 1; cmd_word = 32'h9; done_vld = 1; done_kind = 2'd1;
    done_sub = 4'h8; done_cause = 18'h00200; step();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cmd_wr     = ($urandom_range(0, 2) == 0);
      cmd_word   = $urandom;
      done_vld   = ($urandom_range(0, 2) == 0);
      done_kind  = 2'($urandom);
      done_sub   = 4'($urandom);
      done_cause = pick_cause();
      irq_clr    = ($urandom_range(0, 5) == 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule